// File: doc/BRIEF.md
# Dual-Law Phase Comparator

This block is the phase comparator of a digital phase-locked loop. It takes a reference square wave and a divided-down feedback square wave. Both are asynchronous to a fast system clock, which samples them. A mode input picks one of two comparison laws. The XOR law drives the detector output high whenever the two inputs differ. The edge law uses a set/clear flip-flop: a rising edge on the reference sets it and a rising edge on the feedback clears it. The XOR law only behaves well with 50% duty inputs. The edge law ignores the duty cycle of both inputs and covers twice the phase range (±π against ±π/2).

Besides the one-bit detector output, the block measures how many system clocks the output was high during each reference period. It subtracts half the period length from that count and publishes the result as a signed phase-error word with a one-cycle valid strobe. A digital loop filter can use the word directly. A mode change waits for the next reference rising edge, so a measurement window never mixes two laws in the middle of a period.

Top module: `phase_cmp`

## Requirements
- R1: While `rst` is high at a rising clock edge, after that edge `detOut` is 0, `errValid` is 0 and `errVal` is 0, whatever the inputs do.
- R2: With the XOR law active (`modeSel` encoding 0), `detOut` equals `refIn` XOR `fbIn`. A change on either input becomes visible after the second rising clock edge at which the new level is present.
- R3: With the edge law active (encoding 1), a detected rising edge on `refIn` alone sets the internal state and a detected rising edge on `fbIn` alone clears it. With no edge, the state holds, and `detOut` shows that state one clock after the edge is detected. An edge counts as detected when the synchronised sample is 1 and the previous synchronised sample was 0.
- R4: With the edge law active, rising edges detected on both inputs in the same clock invert the state.
- R5: With the edge law active, the duty cycle of either input has no effect on `detOut` or `errVal`. Only the rising-edge positions matter.
- R6: A new `modeSel` value is taken at the first clock that detects a reference rising edge. In that clock the edge-law state is forced to 0, and that reference edge does not set it. Between reference edges `modeSel` has no effect.
- R7: Each measurement window runs from a clock that detects a reference rising edge, inclusive, to the next such clock, exclusive. At the end of a window, `errVal` = (clocks in the window with `detOut` high) − floor(window length / 2), as a two's-complement value. `errValid` is high for exactly one clock, the clock after the closing edge is detected, and `errVal` holds between strobes.
- R8: The first reference rising edge after reset only opens a window, and no `errValid` strobe follows it.
- R9: The window length and the high count each saturate at 2^CNT_W − 1. A long window with `detOut` always high therefore reports 2^(CNT_W−1).
- R10: The lock points report zero error. In the XOR law, equal 50% duty inputs a quarter period apart give `errVal` = 0. In the edge law, feedback edges half a period after the reference edges give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples both inputs |
| rst | input | 1 | Synchronous active-high reset |
| refIn | input | 1 | Reference square wave, asynchronous |
| fbIn | input | 1 | Divided feedback square wave, asynchronous |
| modeSel | input | 1 | Comparison law: 0 XOR, 1 edge set/clear |
| detOut | output | 1 | Detector output |
| errVal | output | CNT_W+1 | Signed phase error of the last completed reference period |
| errValid | output | 1 | One-cycle strobe marking a new `errVal` |

## Verification
The assertions check on every cycle the rules that hold in any state: the response to reset, the set and toggle of the edge-law state, the clearing on a mode change, the mode register staying fixed between reference edges, the strobe lasting one cycle and following a reference edge, and the window counter never falling inside a window. Only the bench's scenarios can show that the published error has the right value. The bench runs lock points in both laws, in-phase inputs, duty-cycle changes, coincident edges, a frequency offset and saturation, and compares every cycle against a behavioural model of the two laws and the period measurement.

// File: rtl/phase_cmp_pkg.sv
`timescale 1ns/1ps
package phase_cmp_pkg;

  typedef enum logic {
    MODE_XOR  = 1'b0,
    MODE_EDGE = 1'b1
  } cmpMode_e;

  // Control-to-datapath strobes, all valid in the same cycle
  typedef struct packed {
    logic     refRise;     // synchronised reference rising edge
    logic     fbRise;      // synchronised feedback rising edge
    logic     clearState;  // mode change taken this cycle
    logic     refLvl;      // synchronised reference level
    logic     fbLvl;       // synchronised feedback level
    cmpMode_e activeMode;  // law currently in force
  } ctrlStrobes_t;

endpackage

// File: rtl/phase_cmp_sync.sv
`timescale 1ns/1ps
module phase_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic prev
);

  logic [STAGES:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else     shiftReg <= {shiftReg[STAGES-1:0], din};
  end

  assign level = shiftReg[STAGES-1];
  assign prev  = shiftReg[STAGES];

endmodule

// File: rtl/phase_cmp_ctrl.sv
`timescale 1ns/1ps
module phase_cmp_ctrl
  import phase_cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         refIn,
  input  logic         fbIn,
  input  logic         modeSel,
  output ctrlStrobes_t st
);

  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] lvl;
  logic [NUM_IN-1:0] prv;
  cmpMode_e          activeMode;
  cmpMode_e          reqMode;
  logic              refRise;

  assign rawIn = {fbIn, refIn};

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
      phase_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rawIn[g]),
        .level(lvl[g]),
        .prev (prv[g])
      );
    end
  endgenerate

  assign refRise = lvl[0] & ~prv[0];
  assign reqMode = cmpMode_e'(modeSel);

  always_ff @(posedge clk) begin
    if (rst)          activeMode <= MODE_XOR;
    else if (refRise) activeMode <= reqMode;
  end

  always_comb begin
    st.refRise    = refRise;
    st.fbRise     = lvl[1] & ~prv[1];
    st.clearState = refRise && (reqMode != activeMode);
    st.refLvl     = lvl[0];
    st.fbLvl      = lvl[1];
    st.activeMode = activeMode;
  end

  // R6
  modeHold_chk: assert property (@(posedge clk) disable iff (rst)
    !refRise |=> $stable(activeMode));

endmodule

// File: rtl/phase_cmp_dp.sv
`timescale 1ns/1ps
module phase_cmp_dp
  import phase_cmp_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        st,
  output logic                detOut,
  output logic signed [CNT_W:0] errVal,
  output logic                errValid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             jkState;
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] hiCnt;
  logic             armed;
  logic [CNT_W:0]   errNext;

  // Set/clear flip-flop of the edge law
  always_ff @(posedge clk) begin
    if (rst || st.clearState)          jkState <= 1'b0;
    else if (st.refRise && st.fbRise)  jkState <= ~jkState;
    else if (st.refRise)               jkState <= 1'b1;
    else if (st.fbRise)                jkState <= 1'b0;
  end

  assign detOut = (st.activeMode == MODE_EDGE) ? jkState : (st.refLvl ^ st.fbLvl);

  // Window measurement: high count minus half the window length
  assign errNext = {1'b0, hiCnt} - {2'b00, perCnt[CNT_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      perCnt   <= '0;
      hiCnt    <= '0;
      armed    <= 1'b0;
      errVal   <= '0;
      errValid <= 1'b0;
    end else if (st.refRise) begin
      errValid <= armed;
      if (armed) errVal <= $signed(errNext);
      perCnt   <= CNT_ONE;
      hiCnt    <= detOut ? CNT_ONE : '0;
      armed    <= 1'b1;
    end else begin
      errValid <= 1'b0;
      if (perCnt != CNT_MAX)           perCnt <= perCnt + CNT_ONE;
      if (detOut && (hiCnt != CNT_MAX)) hiCnt <= hiCnt + CNT_ONE;
    end
  end

  // R1
  resetQuiet_chk: assert property (@(posedge clk)
    rst |=> (!detOut && !errValid && errVal == '0));

  // R3
  edgeSet_chk: assert property (@(posedge clk) disable iff (rst)
    (st.activeMode == MODE_EDGE && st.refRise && !st.fbRise && !st.clearState) |=> detOut);

  // R4
  edgeToggle_chk: assert property (@(posedge clk) disable iff (rst)
    (st.refRise && st.fbRise && !st.clearState) |=> (jkState != $past(jkState)));

  // R6
  modeClear_chk: assert property (@(posedge clk) disable iff (rst)
    st.clearState |=> !jkState);

  // R7
  strobeOne_chk: assert property (@(posedge clk) disable iff (rst)
    errValid |=> !errValid);

  // R7
  strobeCause_chk: assert property (@(posedge clk) disable iff (rst)
    errValid |-> $past(st.refRise));

  // R9
  winGrow_chk: assert property (@(posedge clk) disable iff (rst)
    !st.refRise |=> (perCnt >= $past(perCnt)));

  // R9
  hiBound_chk: assert property (@(posedge clk) disable iff (rst)
    hiCnt <= perCnt);

endmodule

// File: rtl/phase_cmp.sv
`timescale 1ns/1ps
module phase_cmp
  import phase_cmp_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  refIn,
  input  logic                  fbIn,
  input  logic                  modeSel,
  output logic                  detOut,
  output logic signed [CNT_W:0] errVal,
  output logic                  errValid
);

  ctrlStrobes_t st;

  phase_cmp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .refIn  (refIn),
    .fbIn   (fbIn),
    .modeSel(modeSel),
    .st     (st)
  );

  phase_cmp_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .detOut  (detOut),
    .errVal  (errVal),
    .errValid(errValid)
  );

endmodule

// File: tb/phase_cmp_test.sv
`timescale 1ns/1ps
module phase_cmp_test;

  localparam int CNT_W = 12;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refIn = 1'b0;
  logic fbIn = 1'b0;
  logic modeSel = 1'b0;
  logic detOut;
  logic signed [CNT_W:0] errVal;
  logic errValid;

  always #5 clk = ~clk;

  phase_cmp #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn), .modeSel(modeSel),
    .detOut(detOut), .errVal(errVal), .errValid(errValid)
  );

  int vecCnt = 0;
  int badCnt = 0;
  int ph = 0;
  int lastErr = 0;
  int validCnt = 0;
  bit checking = 0;
  bit done = 0;
  string curReq = "R1";

  // Behavioural model: input history plus the two laws and the window count
  bit refQ[$];
  bit fbQ[$];
  bit mMode, mJk, mArmed, mValid;
  int mPer, mHi, mErr;

  always @(posedge clk) begin
    if (rst) begin
      refQ = '{0, 0, 0};
      fbQ  = '{0, 0, 0};
      mMode = 0; mJk = 0; mArmed = 0; mValid = 0;
      mPer = 0; mHi = 0; mErr = 0;
    end else begin
      bit rr, rf, cd;
      rr = refQ[1] && !refQ[0];
      rf = fbQ[1] && !fbQ[0];
      cd = mMode ? mJk : (refQ[1] ^ fbQ[1]);
      if (rr && (modeSel != mMode)) begin
        mMode = modeSel; mJk = 0;
      end else if (rr && rf) mJk = !mJk;
      else if (rr) mJk = 1;
      else if (rf) mJk = 0;
      if (rr) begin
        mValid = mArmed;
        if (mArmed) mErr = mHi - mPer / 2;
        mPer = 1; mHi = cd; mArmed = 1;
      end else begin
        mValid = 0;
        mPer = (mPer + 1 > MAXC) ? MAXC : mPer + 1;
        mHi  = (mHi + cd > MAXC) ? MAXC : mHi + cd;
      end
      refQ.push_back(refIn); fbQ.push_back(fbIn);
      void'(refQ.pop_front()); void'(fbQ.pop_front());
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      bit expDet;
      int actErr;
      expDet = mMode ? mJk : (refQ[1] ^ fbQ[1]);
      actErr = errVal;
      vecCnt++;
      if (detOut !== expDet || errValid !== mValid || actErr != mErr) begin
        badCnt++;
        $display("FAIL %s det/valid/err act %0d/%0d/%0d exp %0d/%0d/%0d at %0t",
                 curReq, detOut, errValid, actErr, expDet, mValid, mErr, $time);
      end
    end
    if (rst) validCnt = 0;
    else if (errValid) begin
      validCnt++;
      lastErr = errVal;
    end
  end

  task automatic chk(string req, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      badCnt++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic runCycles(int n, int pr, int rh, int pf, int off, int fh);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      refIn = (ph % pr) < rh;
      fbIn  = ((ph + pf * 1000 - off) % pf) < fh;
      ph++;
    end
  endtask

  task automatic holdLevels(int n, bit r, bit f);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      refIn = r; fbIn = f;
    end
  endtask

  initial begin : mainSeq
    // R1: reset with toggling inputs
    rst = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      refIn = i[0]; fbIn = ~i[0]; modeSel = i[1];
      chk("R1 detOut", detOut, 0);
      chk("R1 errValid", errValid, 0);
      chk("R1 errVal", errVal, 0);
    end
    modeSel = 0; refIn = 0; fbIn = 0;
    @(negedge clk);
    rst = 0;
    checking = 1;

    // R8: first reference edge opens a window only
    curReq = "R8";
    runCycles(30, 40, 20, 40, 0, 20);
    chk("R8 no strobe after first edge", validCnt, 0);

    // R2: XOR law, in-phase inputs
    curReq = "R2";
    runCycles(200, 40, 20, 40, 0, 20);
    chk("R2 in-phase error", lastErr, -20);

    // R10: XOR quadrature lock point
    curReq = "R10";
    runCycles(240, 40, 20, 40, 10, 20);
    chk("R10 XOR quadrature error", lastErr, 0);

    // R6: switch to edge law, takes effect at next reference edge
    curReq = "R6";
    modeSel = 1;
    runCycles(120, 40, 20, 40, 10, 20);

    // R3: edge law, feedback 10 clocks late
    curReq = "R3";
    runCycles(200, 40, 20, 40, 10, 20);
    chk("R3 edge error", lastErr, -10);

    // R5: same edges, different duty cycles
    curReq = "R5";
    runCycles(200, 40, 8, 40, 10, 33);
    chk("R5 duty independence", lastErr, -10);

    // R10: edge law half-period lock point
    curReq = "R10";
    runCycles(200, 40, 30, 40, 20, 5);
    chk("R10 edge half-period error", lastErr, 0);

    // R4: coincident rising edges toggle the state
    curReq = "R4";
    runCycles(200, 40, 20, 40, 0, 20);

    // R7: frequency offset in the edge law
    curReq = "R7";
    runCycles(400, 40, 20, 37, 3, 18);

    // R6: back to XOR, edge state cleared
    curReq = "R6";
    modeSel = 0;
    runCycles(160, 40, 20, 40, 0, 20);
    chk("R6 XOR law restored", lastErr, -20);

    // R9: saturation of a very long window
    curReq = "R9";
    holdLevels(5, 0, 1);
    holdLevels(5, 1, 1);
    holdLevels(4200, 0, 1);
    holdLevels(10, 1, 1);
    chk("R9 saturated error", lastErr, 2048);

    // R2: short mixed-phase tail in XOR law
    curReq = "R2";
    runCycles(300, 24, 12, 24, 5, 12);

    done = 1;
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      badCnt++;
      $display("FAIL watchdog act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  end

endmodule